// File: doc/BRIEF.md
# Accumulating Post-Mixer for Pseudo-Random Words

This stage sits behind a pseudo-random generator. It takes one raw word on each accepted input transfer and returns one mixed output word. The mix always folds in the upper half of the word it produced last, which it keeps in a feedback register. Consecutive raw words therefore stop acting as separate samples and become one long chained stream. When the source is a small-state generator, this interleaves its many correlated sub-streams so that each output half is close to equidistributed. For example, 16-bit halves taken from a generator with a 2^33-2 period give a combined period of 2^49-2^17, and every 16-bit value appears 2^33-2 times.

There are two mixing rules, and each input word selects its own. The arithmetic rule adds the raw low half, the previous high half and one, then adds the raw high half to that sum. The xor rule rotates the raw low half left by a parameter amount and xors it with the previous high half. It then xors in the raw high half and finishes with an add of an odd constant. The last step must be an add: xoring the constant instead would break equidistribution.

Both sides use valid/ready. An input transfer happens when `in_valid` and `in_ready` are both high at a clock edge. The result appears in the output register one cycle later. A result that has not been taken holds still and blocks new input, because `in_ready` is low while `out_valid` is high and `out_ready` is low. A full register can take a new word in the same cycle that its old word leaves.

Top module: `prng_accum`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the feedback half is zero, so the first result is mixed against zero.
- R2: In arithmetic mode (`in_mode`=0), the result's low half equals raw low half + previous result's high half + 1, modulo 2^HALF_W.
- R3: In arithmetic mode, the result's high half equals raw high half + the new low half, modulo 2^HALF_W.
- R4: In xor mode (`in_mode`=1), the result's low half equals the raw low half rotated left by ROT_E bits, xored with the previous result's high half.
- R5: In xor mode, the result's high half equals (raw high half xor new low half) + ADD_F, modulo 2^HALF_W. ADD_F is odd, and ROT_E lies in 0..HALF_W-1.
- R6: A result appears with `out_valid` high one cycle after its input transfer. `out_valid` falls after the result is taken, unless a new word was accepted in the same cycle.
- R7: The feedback half changes only on an input transfer. A word or mode that is presented while `in_ready` is low has no effect on later results.
- R8: While `out_valid` is high and `out_ready` is low, `out_word` and `out_valid` hold and `in_ready` is low.
- R9: The mode is taken with each word, so consecutive words may use different modes, and every result uses the feedback left by the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw word offered |
| in_ready | output | 1 | Stage can take a raw word |
| in_mode | input | 1 | 0 = arithmetic mix, 1 = xor/rotate mix |
| in_word | input | 2*HALF_W | Raw pseudo-random word |
| out_valid | output | 1 | Mixed word held |
| out_ready | input | 1 | Consumer takes the mixed word |
| out_word | output | 2*HALF_W | Mixed output word |

## Verification
The bench builds the block with 16-bit halves, a rotation of 5 and an added constant of 9. A nonzero rotation makes a missing or reversed rotate visible. A constant other than one separates the xor-mode tail from the fixed +1 used in arithmetic mode, and from an xor with the constant. Raw words such as all-ones and 0x8001 halves force carries across the top of each half and wrap the rotation. Stalled periods with junk offered at the input confirm that the feedback half moves only on real transfers.

// File: rtl/prng_accum_pkg.sv
package prng_accum_pkg;
  typedef enum logic {
    MIX_ARITH = 1'b0,
    MIX_XROT  = 1'b1
  } mix_mode_e;
endpackage

// File: rtl/accum_mix_arith.sv
module accum_mix_arith #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0] raw_lo,
  input  logic [HALF_W-1:0] raw_hi,
  input  logic [HALF_W-1:0] fb_hi,
  output logic [HALF_W-1:0] mix_lo,
  output logic [HALF_W-1:0] mix_hi
);
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  always_comb begin
    mix_lo = raw_lo + fb_hi + ONE;
    mix_hi = raw_hi + mix_lo;
  end
endmodule

// File: rtl/accum_mix_xrot.sv
module accum_mix_xrot #(
  parameter int HALF_W = 16,
  parameter int ROT_E  = 7,
  parameter int ADD_F  = 1
) (
  input  logic [HALF_W-1:0] raw_lo,
  input  logic [HALF_W-1:0] raw_hi,
  input  logic [HALF_W-1:0] fb_hi,
  output logic [HALF_W-1:0] mix_lo,
  output logic [HALF_W-1:0] mix_hi
);
  localparam logic [HALF_W-1:0] TAIL_K = HALF_W'(ADD_F);

  logic [HALF_W-1:0] rot_lo;

  generate
    if (ROT_E == 0) begin : g_no_rot
      assign rot_lo = raw_lo;
    end else begin : g_rot
      assign rot_lo = {raw_lo[HALF_W-1-ROT_E:0], raw_lo[HALF_W-1:HALF_W-ROT_E]};
    end
  endgenerate

  always_comb begin
    mix_lo = rot_lo ^ fb_hi;
    mix_hi = (raw_hi ^ mix_lo) + TAIL_K;
  end
endmodule

// File: rtl/accum_out_stage.sv
module accum_out_stage #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] next_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [HALF_W-1:0] fb_hi
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      fb_hi     <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_word  <= next_word;
      fb_hi     <= next_word[WORD_W-1:HALF_W];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/prng_accum.sv
module prng_accum
  import prng_accum_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ROT_E  = 7,
  parameter int ADD_F  = 1,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_mode,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word
);
  logic [HALF_W-1:0] fb_hi;
  logic [HALF_W-1:0] ar_lo, ar_hi, xr_lo, xr_hi;
  logic [WORD_W-1:0] next_word;
  logic              take;
  mix_mode_e         mode_sel;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign mode_sel = mix_mode_e'(in_mode);

  accum_mix_arith #(.HALF_W(HALF_W)) arith_i (
    .raw_lo(in_word[HALF_W-1:0]), .raw_hi(in_word[WORD_W-1:HALF_W]),
    .fb_hi(fb_hi), .mix_lo(ar_lo), .mix_hi(ar_hi)
  );

  accum_mix_xrot #(.HALF_W(HALF_W), .ROT_E(ROT_E), .ADD_F(ADD_F)) xrot_i (
    .raw_lo(in_word[HALF_W-1:0]), .raw_hi(in_word[WORD_W-1:HALF_W]),
    .fb_hi(fb_hi), .mix_lo(xr_lo), .mix_hi(xr_hi)
  );

  always_comb begin
    unique case (mode_sel)
      MIX_XROT: next_word = {xr_hi, xr_lo};
      default:  next_word = {ar_hi, ar_lo};
    endcase
  end

  accum_out_stage #(.HALF_W(HALF_W)) out_i (
    .clk(clk), .rst_n(rst_n), .take(take), .next_word(next_word),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word),
    .fb_hi(fb_hi)
  );
endmodule

// File: rtl/prng_accum_chk.sv
module prng_accum_chk #(
  parameter int HALF_W = 16,
  parameter int ROT_E  = 7,
  parameter int ADD_F  = 1,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_mode,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word
);
  logic              acc, acc_d;
  logic [HALF_W-1:0] last_hi, prev_hi, rot_in;

  assign acc     = in_valid && in_ready;
  assign prev_hi = acc_d ? out_word[WORD_W-1:HALF_W] : last_hi;
  assign rot_in  = (in_word[HALF_W-1:0] << ROT_E) | (in_word[HALF_W-1:0] >> (HALF_W - ROT_E));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_d   <= 1'b0;
      last_hi <= '0;
    end else begin
      acc_d   <= acc;
      last_hi <= prev_hi;
    end
  end

  assert_valid_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !acc) |=> !out_valid);

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  assert_block_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_arith_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_mode) |=>
      out_word[HALF_W-1:0] == HALF_W'($past(in_word[HALF_W-1:0]) + $past(prev_hi) + HALF_W'(1)));

  assert_xrot_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode) |=> out_word[HALF_W-1:0] == ($past(rot_in) ^ $past(prev_hi)));
endmodule

bind prng_accum prng_accum_chk #(.HALF_W(HALF_W), .ROT_E(ROT_E), .ADD_F(ADD_F)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .in_word(in_word), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word)
);

// File: tb/prng_accum_tb_top.sv
module prng_accum_tb_top;
  localparam int HW = 16;
  localparam int E  = 5;
  localparam int F  = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_mode = 1'b0, out_ready = 1'b1;
  logic [31:0] in_word = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_word;

  int checks = 0, fails = 0;
  logic [15:0] model_fb = '0;
  logic [32:0] exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  prng_accum #(.HALF_W(HW), .ROT_E(E), .ADD_F(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic m, input logic [31:0] w, input logic [15:0] fb);
    logic [15:0] lo, hi, r;
    if (!m) begin
      lo = w[15:0] + fb + 16'd1;
      hi = w[31:16] + lo;
    end else begin
      r  = (w[15:0] << E) | (w[15:0] >> (16 - E));
      lo = r ^ fb;
      hi = (w[31:16] ^ lo) + 16'(F);
    end
    return {hi, lo};
  endfunction

  // driver: called at a falling edge, returns at the falling edge after the transfer
  task automatic send(input logic m, input logic [31:0] w);
    logic [31:0] e;
    in_valid = 1'b1; in_mode = m; in_word = w;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    e = model(m, w, model_fb);
    model_fb = e[31:16];
    exp_q.push_back({m, e});
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compares each result as it leaves the block
  initial begin
    logic [32:0] it;
    forever begin
      @(negedge clk); #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R6 unexpected result", out_word, 32'hx);
        end else begin
          it = exp_q.pop_front();
          if (!it[32]) begin
            check("R2 arith low", {16'h0, out_word[15:0]}, {16'h0, it[15:0]});
            check("R3 arith high", {16'h0, out_word[31:16]}, {16'h0, it[31:16]});
          end else begin
            check("R4 xor low", {16'h0, out_word[15:0]}, {16'h0, it[15:0]});
            check("R5 xor high", {16'h0, out_word[31:16]}, {16'h0, it[31:16]});
          end
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    #1;
    check("R1 out_valid after reset", {31'h0, out_valid}, 32'h0);
    check("R1 in_ready after reset", {31'h0, in_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first word mixes against zero feedback; R2/R3 arithmetic words incl. wrap
    send(1'b0, 32'h1234_5678);
    send(1'b0, 32'hFFFF_FFFF);
    send(1'b0, 32'h0000_0000);
    // R4/R5 xor words incl. rotate wrap and constant wrap
    send(1'b1, 32'h8001_8001);
    send(1'b1, 32'hFFFF_0000);
    send(1'b1, 32'hA5A5_5A5A);
    // R9 alternating modes back to back
    for (int i = 0; i < 8; i++) send(i[0], 32'h9E37_79B9 * (i + 3));
    @(negedge clk);
    // R6/R8/R7: stall with junk offered
    out_ready = 1'b0;
    send(1'b0, 32'h0BAD_F00D);
    #1;
    check("R6 valid one cycle after transfer", {31'h0, out_valid}, 32'h1);
    held = out_word;
    @(negedge clk);
    in_valid = 1'b1; in_mode = 1'b1; in_word = 32'hDEAD_BEEF;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R8 in_ready low while stalled", {31'h0, in_ready}, 32'h0);
      check("R8 word held while stalled", out_word, held);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    check("R6 valid falls after take", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    // R7: the junk must not have moved the feedback
    send(1'b1, 32'h1357_2468);
    send(1'b0, 32'h2468_1357);
    // toggled back-pressure with back-to-back words
    fork
      begin
        for (int i = 0; i < 10; i++) send(i[1], 32'h7F4A_7C15 ^ (i * 32'h0101_0101));
      end
      begin
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          out_ready = (i % 3) != 1;
        end
        out_ready = 1'b1;
      end
    join
    repeat (5) @(negedge clk);
    check("R6 all results delivered", exp_q.size(), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule